// File: doc/BRIEF.md
# Serial Flash Power-State and Write-Permission Controller

This block sits on the device side of a serial flash target, between the byte shifter and the array timer. It follows the chip-select line and the bytes received in each frame. From these it keeps the power state of the device (active, standby or deep power-down) and decides whether a program, erase or status-register write may begin. It holds the write-enable latch and reports a write-in-progress bit taken from the array timer's busy signal.

The first byte of each frame is the instruction. A write-class instruction is granted on that byte only when three things are true: the write-enable latch is set, the device is not in deep power-down, and no internal cycle is running. A grant sets a pending flag. When the busy signal that follows the grant falls, the cycle is complete and the write-enable latch clears. The power-down entry and release instructions act when chip select rises, and only if the frame held exactly one byte. Standby is reached only when chip select is high and the array timer is idle.

Top module: `flash_pwr_gate`

## Requirements
- R1: After reset, pwr_state is standby (2'd0), wel is 0 and wip is 0.
- R2: One clock edge after chip select is sampled low outside deep power-down, pwr_state is active (2'd1).
- R3: When chip select is high, pwr_state stays active while cyc_busy is 1. It becomes standby on the first clock edge at which chip select is high and cyc_busy is 0.
- R4: A one-byte frame holding the power-down opcode (8'hB9) puts the device into deep power-down (2'd2) on the edge at which chip select rises. The transition is refused if cyc_busy is 1 at that edge.
- R5: Deep power-down is left only through a one-byte frame holding the release opcode (8'hAB). On the chip-select rise of that frame the state becomes standby. A power-down or release opcode in a frame of two or more bytes has no effect.
- R6: While in deep power-down, cmd_accept stays 0 for every opcode, and the write-enable opcode (8'h06) does not set wel.
- R7: cmd_accept pulses on the first byte of a frame only when all of the following hold: the opcode is write-class (program 8'h02, sector erase 8'hD8, bulk erase 8'hC7, status write 8'h01), wel is 1, and cyc_busy is 0. Any other opcode, or the same opcode without a prior write-enable, gives no pulse.
- R8: wip equals cyc_busy, so it reads 1 for the whole internal cycle.
- R9: wel is set by the write-enable opcode. It clears on the clock edge at which cyc_busy falls after a granted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| byte_stb | input | 1 | One-cycle pulse per received byte |
| byte_val | input | 8 | Received byte, valid with byte_stb |
| cyc_busy | input | 1 | Internal array cycle running |
| pwr_state | output | 2 | 0 standby, 1 active, 2 deep power-down |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write-in-progress status bit |
| cmd_accept | output | 1 | Write-class command granted this cycle |

## Verification
The grant logic is driven from a table of cases: each write-class opcode preceded by write-enable, a write-class opcode with no write-enable, a read opcode, and write-class opcodes issued from deep power-down with and without write-enable. Comparing these cases separates the write-enable condition, the opcode class and the power-down block from one another. Directed sequences then cover the following:
- standby being held off while the array is busy;
- power-down refused during a cycle;
- two-byte frames that contain power-down or release opcodes;
- the latch clearing on the falling edge of busy.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_STBY   = 2'd0,
    PWR_ACTIVE = 2'd1,
    PWR_DEEP   = 2'd2
  } pwr_e;
endpackage

// File: rtl/fpg_frame_track.sv
module fpg_frame_track #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           byte_stb,
  input  logic [OPW-1:0] byte_val,
  output logic           op_stb,
  output logic [OPW-1:0] op_code,
  output logic           single_end,
  output logic [OPW-1:0] end_code
);
  logic           cs_q;
  logic [1:0]     cnt_q;
  logic [OPW-1:0] op_q;
  logic           frame_end;

  assign op_stb     = byte_stb & ~cs_n & (cnt_q == 2'd0);
  assign op_code    = byte_val;
  assign frame_end  = cs_n & ~cs_q;
  assign single_end = frame_end & (cnt_q == 2'd1);
  assign end_code   = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      cnt_q <= 2'd0;
      op_q  <= '0;
    end else begin
      cs_q <= cs_n;
      if (frame_end) cnt_q <= 2'd0;
      else if (byte_stb && !cs_n && cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
      if (op_stb) op_q <= byte_val;
    end
  end

  // R5
  multi_byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cnt_q == 2'd0));
endmodule

// File: rtl/fpg_power_fsm.sv
module fpg_power_fsm
  import flash_pwr_pkg::*;
#(
  parameter int             OPW    = 8,
  parameter logic [OPW-1:0] OP_DP  = 8'hB9,
  parameter logic [OPW-1:0] OP_RES = 8'hAB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           cyc_busy,
  input  logic           single_end,
  input  logic [OPW-1:0] end_code,
  output pwr_e           state
);
  logic rel_evt, dp_req, dp_evt;
  pwr_e nxt;

  assign rel_evt = single_end && (end_code == OP_RES);
  assign dp_req  = single_end && (end_code == OP_DP);
  assign dp_evt  = dp_req && !cyc_busy;

  always_comb begin
    nxt = state;
    if (state == PWR_DEEP) begin
      if (rel_evt) nxt = PWR_STBY;
    end else if (dp_evt)   nxt = PWR_DEEP;
    else if (!cs_n)        nxt = PWR_ACTIVE;
    else if (cyc_busy)     nxt = PWR_ACTIVE;
    else                   nxt = PWR_STBY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_STBY;
    else        state <= nxt;
  end

  // R2
  sel_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && state != PWR_DEEP) |=> (state == PWR_ACTIVE));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && state != PWR_DEEP) |=> (state != PWR_STBY));
  // R4
  dp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_req && cyc_busy && state != PWR_DEEP) |=> (state != PWR_DEEP));
  // R5
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_DEEP && !rel_evt) |=> (state == PWR_DEEP));
endmodule

// File: rtl/fpg_write_gate.sv
module fpg_write_gate #(
  parameter int             OPW     = 8,
  parameter logic [OPW-1:0] OP_WREN = 8'h06,
  parameter logic [OPW-1:0] OP_PP   = 8'h02,
  parameter logic [OPW-1:0] OP_SE   = 8'hD8,
  parameter logic [OPW-1:0] OP_BE   = 8'hC7,
  parameter logic [OPW-1:0] OP_WRSR = 8'h01
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_stb,
  input  logic [OPW-1:0] op_code,
  input  logic           deep,
  input  logic           cyc_busy,
  output logic           wel,
  output logic           cmd_accept,
  output logic           cyc_done
);
  function automatic logic is_write_class(input logic [OPW-1:0] op);
    return (op == OP_PP) || (op == OP_SE) || (op == OP_BE) || (op == OP_WRSR);
  endfunction

  logic pend_q, busy_q, wren_evt;

  assign wren_evt   = op_stb && (op_code == OP_WREN) && !deep;
  assign cmd_accept = op_stb && is_write_class(op_code) && wel && !deep && !cyc_busy;
  assign cyc_done   = pend_q && busy_q && !cyc_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= cyc_busy;
      if (cyc_done)        pend_q <= 1'b0;
      else if (cmd_accept) pend_q <= 1'b1;
      if (cyc_done)        wel <= 1'b0;
      else if (wren_evt)   wel <= 1'b1;
    end
  end

  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !wel);
  // R9
  wel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(op_stb && op_code == OP_WREN));
endmodule

// File: rtl/flash_pwr_gate.sv
module flash_pwr_gate
  import flash_pwr_pkg::*;
#(
  parameter int             OPW     = 8,
  parameter logic [OPW-1:0] OP_WREN = 8'h06,
  parameter logic [OPW-1:0] OP_PP   = 8'h02,
  parameter logic [OPW-1:0] OP_SE   = 8'hD8,
  parameter logic [OPW-1:0] OP_BE   = 8'hC7,
  parameter logic [OPW-1:0] OP_WRSR = 8'h01,
  parameter logic [OPW-1:0] OP_DP   = 8'hB9,
  parameter logic [OPW-1:0] OP_RES  = 8'hAB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           byte_stb,
  input  logic [OPW-1:0] byte_val,
  input  logic           cyc_busy,
  output logic [1:0]     pwr_state,
  output logic           wel,
  output logic           wip,
  output logic           cmd_accept
);
  logic           op_stb, single_end, cyc_done;
  logic [OPW-1:0] op_code, end_code;
  pwr_e           state;

  fpg_frame_track #(.OPW(OPW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(byte_stb),
    .byte_val(byte_val), .op_stb(op_stb), .op_code(op_code),
    .single_end(single_end), .end_code(end_code));

  fpg_power_fsm #(.OPW(OPW), .OP_DP(OP_DP), .OP_RES(OP_RES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cyc_busy(cyc_busy),
    .single_end(single_end), .end_code(end_code), .state(state));

  fpg_write_gate #(.OPW(OPW), .OP_WREN(OP_WREN), .OP_PP(OP_PP), .OP_SE(OP_SE),
                   .OP_BE(OP_BE), .OP_WRSR(OP_WRSR)) u_gate (
    .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_code(op_code),
    .deep(state == PWR_DEEP), .cyc_busy(cyc_busy), .wel(wel),
    .cmd_accept(cmd_accept), .cyc_done(cyc_done));

  assign pwr_state = state;
  assign wip       = cyc_busy;

  // R6
  deep_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_DEEP) |-> !cmd_accept);
  // R7
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !cmd_accept);
endmodule

// File: tb/tb_flash_pwr_gate.sv
module tb_flash_pwr_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] WREN = 8'h06, PP = 8'h02, SE = 8'hD8, BE = 8'hC7,
                         WRSR = 8'h01, DP = 8'hB9, RES = 8'hAB, RD = 8'h03;
  localparam logic [1:0] ST_STBY = 2'd0, ST_ACT = 2'd1, ST_DEEP = 2'd2;
  // fields: [10] enter deep first, [9] write-enable first, [8:1] opcode, [0] expected grant
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b1, PP,   1'b1},
    {1'b0, 1'b0, SE,   1'b0},
    {1'b0, 1'b1, BE,   1'b1},
    {1'b0, 1'b1, WRSR, 1'b1},
    {1'b0, 1'b1, SE,   1'b1},
    {1'b0, 1'b1, RD,   1'b0},
    {1'b1, 1'b1, PP,   1'b0},
    {1'b1, 1'b0, BE,   1'b0}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, byte_stb = 0, cyc_busy = 0;
  logic [7:0] byte_val = 0;
  logic [1:0] pwr_state;
  logic wel, wip, cmd_accept;
  int checks = 0, fails = 0, cycles = 0;
  logic acc;

  flash_pwr_gate dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(byte_stb),
    .byte_val(byte_val), .cyc_busy(cyc_busy), .pwr_state(pwr_state), .wel(wel),
    .wip(wip), .cmd_accept(cmd_accept));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cs_n = 1; byte_stb = 0; cyc_busy = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  // frame of nb bytes, first byte b0, rest 8'h00; acc holds grant on first byte
  task automatic frame(input int nb, input logic [7:0] b0, input logic busy_at_end);
    @(negedge clk); cs_n = 0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); byte_stb = 1; byte_val = (i == 0) ? b0 : 8'h00;
      #1; if (i == 0) acc = cmd_accept;
      @(negedge clk); byte_stb = 0;
    end
    @(negedge clk); cs_n = 1;
    if (busy_at_end) cyc_busy = 1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 state", pwr_state, ST_STBY);
    chk("R1 wel", wel, 0);
    chk("R1 wip", wip, 0);

    // grant table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      if (VEC[v][10]) begin
        frame(1, DP, 0);
        chk("R4 deep entry", pwr_state, ST_DEEP);
      end
      if (VEC[v][9]) begin
        frame(1, WREN, 0);
        chk("R9/R6 wel after write-enable", wel, VEC[v][10] ? 0 : 1);
      end
      frame(4, VEC[v][8:1], 0);
      chk("R7/R6 grant", acc, VEC[v][0]);
      if (VEC[v][10]) begin
        chk("R6 still deep", pwr_state, ST_DEEP);
        frame(1, RES, 0);
        chk("R5 release", pwr_state, ST_STBY);
      end
    end

    // R2 active on select
    do_reset();
    @(negedge clk); cs_n = 0;
    @(negedge clk);
    chk("R2 active", pwr_state, ST_ACT);
    cs_n = 1;
    @(negedge clk);
    chk("R3 standby idle", pwr_state, ST_STBY);

    // R3 / R8 / R9: granted cycle
    frame(1, WREN, 0);
    frame(4, PP, 1);
    chk("R7 grant PP", acc, 1);
    chk("R3 active while busy", pwr_state, ST_ACT);
    chk("R8 wip busy", wip, 1);
    chk("R9 wel held during cycle", wel, 1);
    // R4 refused during busy
    frame(1, DP, 0);
    chk("R4 refused while busy", pwr_state, ST_ACT);
    // R7 no grant while busy even with wel
    frame(4, SE, 0);
    chk("R7 no grant busy", acc, 0);
    repeat (3) @(negedge clk);
    cyc_busy = 0;
    @(negedge clk);
    chk("R3 standby after cycle", pwr_state, ST_STBY);
    chk("R8 wip idle", wip, 0);
    chk("R9 wel cleared", wel, 0);

    // R5 multi-byte DP/RES ignored
    frame(2, DP, 0);
    chk("R5 two-byte DP ignored", pwr_state, ST_STBY);
    frame(1, DP, 0);
    chk("R4 deep", pwr_state, ST_DEEP);
    frame(2, RES, 0);
    chk("R5 two-byte release ignored", pwr_state, ST_DEEP);
    frame(1, WREN, 0);
    chk("R6 wel ignored in deep", wel, 0);
    @(negedge clk); cs_n = 0;
    @(negedge clk);
    chk("R5 select keeps deep", pwr_state, ST_DEEP);
    cs_n = 1;
    frame(1, RES, 0);
    chk("R5 release to standby", pwr_state, ST_STBY);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule